// File: doc/BRIEF.md
# Temperature-Driven PWM Fan Controller

This block drives a fan through a pulse-width-modulated pin whose period is a fixed count of clock cycles chosen when the core is built. The high time within each period, the width, comes either from software, which writes a new width with a one-cycle strobe, or from the block itself. The block watches a raw temperature code and sorts it into three bands, cool, warm and hot, with hysteresis. Each band has its own width step.

The raw temperature code converts to degrees Celsius as code × 501.3743 / 65536 − 273.6777. All thresholds are compared in raw code units, so no conversion logic is needed. When the band rises, the block loads the band's width and pulses a temperature-rise event. It then waits a parameterized settle interval of clock cycles, about five seconds in the field, so that the fan speed can stabilize. After that wait it pulses a width-changed event. A software write also pulses the width-changed event, one cycle later.

A new width is never applied in the middle of a period. It is latched as the period counter wraps, so the pin never glitches. The duty cycle is the width divided by the period. A width of zero holds the pin low. A width at or above the period holds the pin high for the whole period.

Top module: `fan_pwm_ctrl`

## Requirements
- R1: `period_o` always equals the `PERIOD` parameter, which is at least 2 and so never zero.
- R2: Within each period the phase counts 0 to PERIOD−1. `pwm_o` is high exactly while the phase is below the applied width, so a width of 0 keeps `pwm_o` low.
- R3: A requested width above PERIOD is clamped to PERIOD, and `pwm_o` then stays high for every cycle of the period.
- R4: `width_o` shows the applied width. It changes only at the edge where the phase wraps from PERIOD−1 to 0, and it then takes the width requested before that edge.
- R5: Band selection with hysteresis works as follows. Band 0 (cool) moves up to band 1 when temp ≥ MID_ON and to band 2 when temp ≥ HOT_ON. Band 1 falls to 0 when temp < MID_OFF and rises to 2 when temp ≥ HOT_ON. Band 2 leaves only when temp < HOT_OFF, going to band 1, or to band 0 if temp < MID_OFF. The bands request the widths W_LOW, W_MID and W_FULL.
- R6: `temp_up_o` pulses for one cycle, the cycle after the clock edge at which the band number increases. A band decrease gives no pulse.
- R7: `pwm_chg_o` pulses exactly SETTLE_CYCLES cycles after any hardware band change. A further band change during the wait restarts the wait.
- R8: A software write (`sw_wr_i`), made while the band stays unchanged, requests `sw_width_i`. It pulses `pwm_chg_o` in the next cycle and cancels any pending settle wait.
- R9: When a band change and a software write fall in the same cycle, the band change wins and the written width is discarded.
- R10: After reset the band is 0, the requested and applied width are W_LOW clamped to PERIOD, the phase is 0, and both event outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| temp_i | input | TEMP_W | Raw temperature code |
| sw_width_i | input | WIDTH_W | Width written by software |
| sw_wr_i | input | 1 | One-cycle write strobe for `sw_width_i` |
| pwm_o | output | 1 | Fan PWM pin |
| width_o | output | WIDTH_W | Width applied in the current period |
| period_o | output | WIDTH_W | Fixed PWM period in clock cycles |
| temp_up_o | output | 1 | Temperature-rise event pulse |
| pwm_chg_o | output | 1 | Width-changed event pulse |

## Verification
The assertions take the following for granted:
- The parameters are ordered MID_OFF < MID_ON ≤ HOT_OFF < HOT_ON.
- PERIOD is at least 2 and SETTLE_CYCLES is at least 1.
- `temp_i`, `sw_width_i` and `sw_wr_i` are steady around each rising clock edge.

The stimulus meets these conditions by changing every input only at falling edges. The bench also overrides the settle interval with a few tens of cycles, so that whole band-change sequences fit in a short run.

// File: rtl/fan_pwm_ctrl.sv
module fan_pwm_ctrl #(
  parameter int TEMP_W        = 16,
  parameter int WIDTH_W       = 16,
  parameter int PERIOD        = 1000,
  parameter int SETTLE_CYCLES = 500_000_000,
  parameter int MID_ON        = 41003,
  parameter int MID_OFF       = 40350,
  parameter int HOT_ON        = 43617,
  parameter int HOT_OFF       = 42963,
  parameter int W_LOW         = 250,
  parameter int W_MID         = 600,
  parameter int W_FULL        = 1000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [TEMP_W-1:0]  temp_i,
  input  logic [WIDTH_W-1:0] sw_width_i,
  input  logic               sw_wr_i,
  output logic               pwm_o,
  output logic [WIDTH_W-1:0] width_o,
  output logic [WIDTH_W-1:0] period_o,
  output logic               temp_up_o,
  output logic               pwm_chg_o
);

  localparam int PH_W  = $clog2(PERIOD);
  localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
  localparam logic [WIDTH_W-1:0] PER_W  = WIDTH_W'(PERIOD);
  localparam logic [WIDTH_W-1:0] INIT_W = WIDTH_W'((W_LOW > PERIOD) ? PERIOD : W_LOW);
  localparam logic [PH_W-1:0]    PH_END = PH_W'(PERIOD - 1);
  localparam logic [CNT_W-1:0]   SETTLE = CNT_W'(SETTLE_CYCLES);

  logic [PH_W-1:0]    phase;
  logic [WIDTH_W-1:0] req_w, cur_w, clamp_w, step_w;
  logic [1:0]         lvl, lvl_nxt;
  logic [CNT_W-1:0]   wait_cnt;
  logic               tu_q, pc_q, wrap, lvl_chg;

  always_comb begin
    case (lvl)
      2'd0:    lvl_nxt = (temp_i >= TEMP_W'(HOT_ON)) ? 2'd2 :
                         (temp_i >= TEMP_W'(MID_ON)) ? 2'd1 : 2'd0;
      2'd1:    lvl_nxt = (temp_i >= TEMP_W'(HOT_ON)) ? 2'd2 :
                         (temp_i <  TEMP_W'(MID_OFF)) ? 2'd0 : 2'd1;
      default: lvl_nxt = (temp_i >= TEMP_W'(HOT_OFF)) ? 2'd2 :
                         (temp_i <  TEMP_W'(MID_OFF)) ? 2'd0 : 2'd1;
    endcase
    case (lvl_nxt)
      2'd0:    step_w = WIDTH_W'(W_LOW);
      2'd1:    step_w = WIDTH_W'(W_MID);
      default: step_w = WIDTH_W'(W_FULL);
    endcase
  end

  assign lvl_chg   = lvl_nxt != lvl;
  assign wrap      = phase == PH_END;
  assign clamp_w   = (req_w > PER_W) ? PER_W : req_w;
  assign pwm_o     = WIDTH_W'(phase) < cur_w;
  assign width_o   = cur_w;
  assign period_o  = PER_W;
  assign temp_up_o = tu_q;
  assign pwm_chg_o = pc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= '0;
      lvl      <= 2'd0;
      req_w    <= WIDTH_W'(W_LOW);
      cur_w    <= INIT_W;
      wait_cnt <= '0;
      tu_q     <= 1'b0;
      pc_q     <= 1'b0;
    end else begin
      phase <= wrap ? '0 : phase + 1'b1;
      if (wrap) cur_w <= clamp_w;
      lvl  <= lvl_nxt;
      tu_q <= lvl_nxt > lvl;
      pc_q <= 1'b0;
      if (lvl_chg) begin
        req_w    <= step_w;
        wait_cnt <= SETTLE;
      end else if (sw_wr_i) begin
        req_w    <= sw_width_i;
        wait_cnt <= '0;
        pc_q     <= 1'b1;
      end else if (wait_cnt != '0) begin
        wait_cnt <= wait_cnt - 1'b1;
        if (wait_cnt == CNT_W'(1)) pc_q <= 1'b1;
      end
    end
  end

  // R4
  width_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(width_o));

  // R3
  full_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (width_o == PER_W) |-> pwm_o);

  // R7
  tu_no_chg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    temp_up_o |-> !pwm_chg_o);

  // R8
  sw_chg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr_i && !lvl_chg) |=> pwm_chg_o);

  // R5
  hot_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (temp_i >= TEMP_W'(HOT_ON)) |=> (lvl == 2'd2));

endmodule

// File: tb/tb_fan_pwm_ctrl.sv
module tb_fan_pwm_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int P = 10, S = 20;
  localparam int MON = 1000, MOFF = 900, HON = 2000, HOFF = 1800;
  localparam int WL = 3, WM = 6, WF = 10;

  logic clk = 0, rst_n = 0, sw_wr = 0;
  logic [15:0] temp = 0;
  logic [7:0] sw_width = 0;
  logic pwm, tu, pc;
  logic [7:0] width, period;

  fan_pwm_ctrl #(.TEMP_W(16), .WIDTH_W(8), .PERIOD(P), .SETTLE_CYCLES(S),
    .MID_ON(MON), .MID_OFF(MOFF), .HOT_ON(HON), .HOT_OFF(HOFF),
    .W_LOW(WL), .W_MID(WM), .W_FULL(WF)) dut (
    .clk(clk), .rst_n(rst_n), .temp_i(temp), .sw_width_i(sw_width),
    .sw_wr_i(sw_wr), .pwm_o(pwm), .width_o(width), .period_o(period),
    .temp_up_o(tu), .pwm_chg_o(pc));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0, cmp_on = 0;
  int m_phase, m_lvl, m_req, m_cur, m_cnt, m_tu, m_pc, nl;
  int steps[3] = '{WL, WM, WF};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_lvl = 0; m_req = WL; m_cur = (WL > P) ? P : WL;
      m_cnt = 0; m_tu = 0; m_pc = 0;
    end else begin
      if (temp >= HON) nl = 2;
      else if (m_lvl == 2 && temp >= HOFF) nl = 2;
      else if (temp >= MON) nl = 1;
      else if (m_lvl >= 1 && temp >= MOFF) nl = 1;
      else nl = 0;
      if (m_phase == P - 1) begin
        m_cur = (m_req > P) ? P : m_req;
        m_phase = 0;
      end else m_phase++;
      m_tu = (nl > m_lvl);
      m_pc = 0;
      if (nl != m_lvl) begin m_req = steps[nl]; m_cnt = S; end
      else if (sw_wr) begin m_req = sw_width; m_cnt = 0; m_pc = 1; end
      else if (m_cnt > 0) begin m_cnt--; if (m_cnt == 0) m_pc = 1; end
      m_lvl = nl;
    end
  end

  always @(negedge clk) if (cmp_on) begin
    chk(pwm == (m_phase < m_cur), "R2/R3 pwm_o", pwm, m_phase < m_cur);
    chk(width == m_cur, "R4 width_o", width, m_cur);
    chk(tu == m_tu[0], "R6 temp_up_o", tu, m_tu);
    chk(pc == m_pc[0], "R7/R8 pwm_chg_o", pc, m_pc);
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input int v);
    @(negedge clk); sw_width = 8'(v); sw_wr = 1;
    @(negedge clk); sw_wr = 0;
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    report();
  end

  initial begin
    cyc(3);
    rst_n = 1;
    cmp_on = 1;
    @(negedge clk);
    // R10 reset state, R1 period
    chk(period == P, "R1 period_o", period, P);
    chk(width == WL, "R10 width_o", width, WL);
    chk(tu == 0 && pc == 0, "R10 events", {tu, pc}, 0);
    cyc(2 * P);
    wr(5);  cyc(3 * P);
    chk(width == 5, "R4 sw width applied", width, 5);
    wr(0);  cyc(3 * P);
    chk(width == 0 && pwm == 0, "R2 zero width low", pwm, 0);
    wr(255); cyc(2 * P + 1);
    // R3 clamp: high for a whole period
    chk(width == P, "R3 clamp width", width, P);
    for (int i = 0; i < P; i++) begin
      chk(pwm == 1, "R3 full high", pwm, 1);
      @(negedge clk);
    end
    // R5/R6/R7 rise to band 1
    temp = 1000; cyc(S + 2 * P);
    chk(width == WM, "R5 mid width", width, WM);
    temp = 950;  cyc(2 * P);
    chk(width == WM, "R5 hysteresis hold", width, WM);
    temp = 899;  cyc(S + 2 * P);
    chk(width == WL, "R5 fall to low", width, WL);
    temp = 2000; cyc(5);
    temp = 1900; cyc(5);
    temp = 1700; cyc(S + 2 * P);
    chk(width == WM, "R7 restart to mid", width, WM);
    // R8 write cancels pending wait
    temp = 2100; cyc(4);
    wr(4);       cyc(S + 2 * P);
    chk(width == 4, "R8 sw after hw", width, 4);
    // R9 simultaneous change and write
    @(negedge clk); temp = 500; sw_width = 9; sw_wr = 1;
    @(negedge clk); sw_wr = 0;
    cyc(S + 2 * P);
    chk(width == WL, "R9 hw wins", width, WL);
    wr(7); cyc(P);
    @(negedge clk); temp = 2500; cyc(3 * S);
    chk(width == WF, "R5 hot width", width, WF);
    report();
  end
endmodule